// File: doc/BRIEF.md
# Programmable Edge-Offset Waveform Generator

This block drives a single periodic digital output whose high and low transitions are placed at programmable offsets inside each period. A prescaler divides the master clock into ticks, and a phase counter steps once per tick through the period. When the phase equals the programmed set offset, the output goes high. When it equals the clear offset, the output goes low.

The configuration (prescale, period, set offset, clear offset) is taken from inputs that the surrounding logic holds in registers. The block copies them at reset and again at every period wrap, so a new setting never takes effect partway through a period. The output level is not touched at the wrap; only the two offset matches move it.

Top module: `pulse_shaper`

## Requirements
- R1: While `rst` is high on a rising clock edge, `wave_out` becomes 0, the prescaler and phase counter restart at 0, and all four configuration inputs are copied.
- R2: A tick occurs on every max(S,1)-th enabled clock, where S is the active prescale value, so S=0 behaves as S=1. With `en` held high after reset, tick number k (k counted from 0) happens on rising edge (k+1)*max(S,1) after the reset edge.
- R3: The phase of tick k is k mod max(P,1), where P is the active period, so the counter wraps after P ticks.
- R4: On a tick whose phase equals the active set offset, and does not equal the clear offset, `wave_out` is 1 from that clock edge on.
- R5: On a tick whose phase equals the active clear offset, `wave_out` is 0 from that clock edge on.
- R6: When the set and clear offsets are equal, the clear wins and the output stays 0.
- R7: A period wrap does not change `wave_out`. A high level carries into the next period until the clear offset matches.
- R8: An offset equal to or larger than the active period never matches, so that edge never appears.
- R9: While `en` is low, the prescaler, the phase counter and `wave_out` all hold their values.
- R10: Configuration inputs that change during a period have no effect until the tick that ends that period. From the following tick on, the new values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable for the prescaler and phase counter |
| scale_cfg | input | SCALE_W | Master clocks per tick (0 treated as 1) |
| period_cfg | input | PER_W | Ticks per period (0 treated as 1) |
| rise_cfg | input | PER_W | Phase at which the output is set |
| fall_cfg | input | PER_W | Phase at which the output is cleared |
| wave_out | output | 1 | Generated waveform |

## Verification
The output is registered, so each offset match shows on `wave_out` right after the clock edge that carries the tick: rising edge (k+1)*max(S,1) for tick k. There is no extra pipeline stage. Every check is therefore set up from reset release as "after n edges, the level is the one left by the last of floor(n/max(S,1)) ticks". The bench samples on the falling edge that follows edge n. Enable pauses and configuration changes are checked by counting edges on both sides of the event. The chosen edge counts fall on cycles where a design that kept counting, or that took new settings early, would show the opposite level.

// File: rtl/pulse_shaper.sv
module pulse_shaper #(
  parameter int SCALE_W = 8,
  parameter int PER_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [SCALE_W-1:0] scale_cfg,
  input  logic [PER_W-1:0]   period_cfg,
  input  logic [PER_W-1:0]   rise_cfg,
  input  logic [PER_W-1:0]   fall_cfg,
  output logic               wave_out
);
  localparam logic [SCALE_W-1:0] SCALE_ONE = {{(SCALE_W-1){1'b0}}, 1'b1};
  localparam logic [PER_W-1:0]   PER_ONE   = {{(PER_W-1){1'b0}}, 1'b1};

  logic [SCALE_W-1:0] scale_q, pre_q;
  logic [PER_W-1:0]   per_q, rise_q, fall_q, ph_q;

  wire [SCALE_W-1:0] pre_last = (scale_q == '0) ? '0 : scale_q - SCALE_ONE;
  wire [PER_W-1:0]   ph_last  = (per_q == '0) ? '0 : per_q - PER_ONE;
  wire               tick     = en && (pre_q == pre_last);
  wire               wrap     = tick && (ph_q == ph_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q  <= scale_cfg;
      per_q    <= period_cfg;
      rise_q   <= rise_cfg;
      fall_q   <= fall_cfg;
      pre_q    <= '0;
      ph_q     <= '0;
      wave_out <= 1'b0;
    end else begin
      if (en) pre_q <= tick ? '0 : pre_q + SCALE_ONE;
      if (tick) begin
        ph_q <= wrap ? '0 : ph_q + PER_ONE;
        if (ph_q == fall_q)      wave_out <= 1'b0;
        else if (ph_q == rise_q) wave_out <= 1'b1;
      end
      if (wrap) begin
        scale_q <= scale_cfg;
        per_q   <= period_cfg;
        rise_q  <= rise_cfg;
        fall_q  <= fall_cfg;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !wave_out && ph_q == '0 && pre_q == '0);

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst) ph_q <= ph_last);

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst) wrap |=> ph_q == '0);

  // R4
  rise_set_chk: assert property (@(posedge clk) disable iff (rst)
    tick && ph_q == rise_q && ph_q != fall_q |=> wave_out);

  // R5
  fall_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tick && ph_q == fall_q |=> !wave_out);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(wave_out));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pre_q) && $stable(ph_q));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(per_q) && $stable(rise_q) && $stable(fall_q) && $stable(scale_q));
endmodule

// File: tb/pulse_shaper_test.sv
`timescale 1ns/1ps
module pulse_shaper_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] scale_cfg = 8'd1, period_cfg = 8'd8, rise_cfg = 8'd2, fall_cfg = 8'd5;
  logic wave_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_shaper #(.SCALE_W(8), .PER_W(8)) uut (
    .clk(clk), .rst(rst), .en(en), .scale_cfg(scale_cfg), .period_cfg(period_cfg),
    .rise_cfg(rise_cfg), .fall_cfg(fall_cfg), .wave_out(wave_out));

  // columns: scale, period, rise, fall, edges after reset, expected level, requirement
  localparam int NV = 16;
  localparam int VEC [NV][7] = '{
    '{1, 8, 2, 5,  2, 0,  4},  // R4 before set offset
    '{1, 8, 2, 5,  3, 1,  4},  // R4 set offset reached
    '{1, 8, 2, 5,  6, 0,  5},  // R5 clear offset reached
    '{1, 8, 2, 5,  9, 0,  3},  // R3 wrap to phase 0
    '{1, 8, 2, 5, 11, 1,  3},  // R3 second period set
    '{1, 4, 2, 1,  5, 1,  7},  // R7 high carried over wrap
    '{1, 4, 2, 1,  6, 0,  7},  // R7 cleared in next period
    '{3, 4, 1, 3,  5, 0,  2},  // R2 one tick only
    '{3, 4, 1, 3,  6, 1,  2},  // R2 second tick sets
    '{3, 4, 1, 3, 12, 0,  2},  // R2 fourth tick clears
    '{0, 4, 1, 3,  1, 0,  2},  // R2 scale 0 as 1
    '{0, 4, 1, 3,  2, 1,  2},  // R2 scale 0 as 1
    '{1, 4, 2, 2,  3, 0,  6},  // R6 clear wins
    '{1, 4, 2, 2, 20, 0,  6},  // R6 over many periods
    '{1, 4, 4, 1, 10, 0,  8},  // R8 set offset out of range
    '{1, 4, 1, 7, 30, 1,  8}   // R8 clear offset out of range
  };

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (wave_out !== exp) begin
      errors++;
      $display("FAIL %s: wave_out=%0b expected %0b", tag, wave_out, exp);
    end
  endtask

  task automatic restart(input int s, input int p, input int r, input int f);
    @(negedge clk);
    scale_cfg = 8'(s); period_cfg = 8'(p); rise_cfg = 8'(r); fall_cfg = 8'(f);
    rst = 1'b1; en = 1'b0;
    @(negedge clk);
    rst = 1'b0; en = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 reset level", 1'b0);
    for (int i = 0; i < NV; i++) begin
      restart(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      run(VEC[i][4]);
      chk($sformatf("R%0d vector %0d", VEC[i][6], i), VEC[i][5] != 0);
    end
    // R1 reset from a high level restarts the phase
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset forces low", 1'b0);
    rst = 1'b0;
    run(2);
    chk("R1 phase restarted", 1'b1);
    // R9 enable low freezes everything
    restart(1, 8, 2, 5);
    run(3);
    en = 1'b0;
    run(10);
    chk("R9 level held while disabled", 1'b1);
    en = 1'b1;
    run(2);
    chk("R9 phase resumed not skipped", 1'b1);
    run(1);
    chk("R9 clear after resume", 1'b0);
    // R10 new configuration waits for the wrap
    restart(1, 8, 2, 5);
    run(3);
    rise_cfg = 8'd4; fall_cfg = 8'd7;
    run(3);
    chk("R10 old clear offset still active", 1'b0);
    run(7);
    chk("R10 new set offset after wrap", 1'b1);
    run(3);
    chk("R10 new clear offset after wrap", 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule